// File: doc/BRIEF.md
# Speech Volume and Trim Gain Stage

This block sits on the playback path of a voice codec and scales 16-bit signed speech samples before they reach the interpolation and conversion stages. The gain has two parts. A coarse volume setting attenuates in 6 dB steps, from 0 dB down to -24 dB. A fine trim adjusts the level from -6 dB to +6 dB in 1 dB steps, so the level can be matched to the transducer in use.

Two controls override the gain. Mute forces the output to silence. Bypass passes each sample through with no gain applied. Samples arrive one at a time with a valid strobe, usually at 8 kHz or 16 kHz, so many idle clocks separate them. A sample is still accepted on every clock if it is presented that way.

The settings are plain register inputs. They are captured together with each sample, so a change between samples never alters a sample that has already been accepted. Each result appears a fixed two cycles after its sample.

Top module: `speech_gain_stage`

## Requirements
- R1: After reset, `outValid` is 0 and `outSample` is 0.
- R2: A sample accepted with `inValid` high on clock edge n is presented on `outSample`, with `outValid` high, after edge n+1. `outValid` is high for exactly one cycle per accepted sample. `outSample` holds its value in cycles where no result is produced.
- R3: `volSel` value v in 0..4 applies an arithmetic right shift by v bits, which is -6·v dB and rounds toward minus infinity. Codes 5..7 behave as 4.
- R4: `trimSel` value t in 0..12 applies a gain of (t-6) dB. It does this by multiplying by the Q2.14 coefficient round(16384·10^((t-6)/20)). Code 6 is exactly 16384, which is unity gain. Codes 13..15 behave as 12.
- R5: The trimmed result equals floor((s·c + 8192) / 16384), where s is the shifted sample and c is the coefficient. This is rounding to nearest.
- R6: A trimmed result above 32767 is clamped to 32767. A result below -32768 is clamped to -32768.
- R7: With `muteEn` set, the output for the sample is 0. Mute takes priority over bypass.
- R8: With `bypassEn` set and `muteEn` clear, the output equals the input sample unchanged. Volume and trim are ignored.
- R9: The settings that apply to a sample are those present in the cycle in which `inValid` is high for that sample. Changes made after that cycle do not affect that sample's result.
- R10: Samples presented on consecutive cycles are each processed with their own settings. The results come out on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input sample strobe |
| inSample | input | 16 | Signed input speech sample |
| volSel | input | 3 | Coarse volume code, 6 dB per step of attenuation |
| trimSel | input | 4 | Fine trim code; 6 means 0 dB |
| muteEn | input | 1 | Force silence |
| bypassEn | input | 1 | Pass samples without gain |
| outValid | output | 1 | Result strobe |
| outSample | output | 16 | Signed scaled speech sample |

## Verification
Mute and bypass can both be asserted for the same sample. The bench presents that collision with a non-zero sample and expects silence, because mute takes priority. A second collision is a settings change in the cycle right after a sample is accepted. The bench drives new volume, trim and mute values with no strobe and checks that the pending result still reflects the old settings. A back-to-back stream then flips the settings on every cycle and compares each result against a model computed in the bench.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 17;
  localparam int FRAC_W   = 14;
  localparam int SHIFT_W  = 3;
  localparam int TSEL_W   = 4;

  typedef struct packed {
    logic                load;
    logic                finish;
    logic [SHIFT_W-1:0]  shift;
    logic [COEF_W-1:0]   coef;
    logic                mute;
    logic                bypass;
  } gain_ctl_t;

  // Q2.14 trim coefficients, index 6 = unity
  function automatic logic [COEF_W-1:0] trimCoef(input logic [TSEL_W-1:0] idx);
    logic [COEF_W-1:0] c;
    case (idx)
      4'd0:    c = 17'd8211;
      4'd1:    c = 17'd9213;
      4'd2:    c = 17'd10338;
      4'd3:    c = 17'd11599;
      4'd4:    c = 17'd13014;
      4'd5:    c = 17'd14602;
      4'd6:    c = 17'd16384;
      4'd7:    c = 17'd18383;
      4'd8:    c = 17'd20626;
      4'd9:    c = 17'd23143;
      4'd10:   c = 17'd25967;
      4'd11:   c = 17'd29135;
      default: c = 17'd32690;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sgs_ctrl.sv
module sgs_ctrl
  import sgs_pkg::*;
#(
  parameter int VOL_MAX  = 4,
  parameter int TRIM_MAX = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [SHIFT_W-1:0] volSel,
  input  logic [TSEL_W-1:0]  trimSel,
  input  logic               muteEn,
  input  logic               bypassEn,
  output gain_ctl_t          ctl,
  output logic               outValid
);

  logic               stage1Valid;
  logic [SHIFT_W-1:0] volEff;
  logic [TSEL_W-1:0]  trimEff;

  // clamp out-of-range codes to the deepest / highest setting (R3, R4)
  always_comb begin
    volEff  = (volSel  > SHIFT_W'(VOL_MAX))  ? SHIFT_W'(VOL_MAX) : volSel;
    trimEff = (trimSel > TSEL_W'(TRIM_MAX)) ? TSEL_W'(TRIM_MAX) : trimSel;
  end

  always_comb begin
    ctl.load   = inValid;
    ctl.finish = stage1Valid;
    ctl.shift  = volEff;
    ctl.coef   = trimCoef(trimEff);
    ctl.mute   = muteEn;
    ctl.bypass = bypassEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  // R2: every accepted sample yields a result two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> ##1 outValid);

  // R2: no result without a sample
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ##1 !outValid);

endmodule

// File: rtl/sgs_datapath.sv
module sgs_datapath
  import sgs_pkg::*;
#(
  parameter int DATA_W = SAMPLE_W,
  parameter int CW     = COEF_W,
  parameter int FW     = FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gain_ctl_t         ctl,
  input  logic [DATA_W-1:0] inSample,
  output logic [DATA_W-1:0] outSample
);

  localparam int PROD_W = DATA_W + CW;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1) << (FW - 1);
  localparam logic signed [SUM_W-1:0] SAT_HI   = SUM_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO   = -SAT_HI - SUM_W'(1);

  logic signed [DATA_W-1:0] s1Shifted;
  logic [DATA_W-1:0]        s1Raw;
  logic [CW-1:0]            s1Coef;
  logic                     s1Mute;
  logic                     s1Bypass;

  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  rounded;
  logic [DATA_W-1:0]        satVal;

  // stage 1: capture sample with its settings, apply coarse volume shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Shifted <= '0;
      s1Raw     <= '0;
      s1Coef    <= '0;
      s1Mute    <= 1'b0;
      s1Bypass  <= 1'b0;
    end else if (ctl.load) begin
      s1Shifted <= $signed(inSample) >>> ctl.shift;
      s1Raw     <= inSample;
      s1Coef    <= ctl.coef;
      s1Mute    <= ctl.mute;
      s1Bypass  <= ctl.bypass;
    end
  end

  // fine trim: multiply, round to nearest, saturate
  always_comb begin
    prod    = $signed(s1Shifted) * $signed({1'b0, s1Coef[CW-2:0]});
    rounded = (SUM_W'(prod) + HALF_LSB) >>> FW;
    if (rounded > SAT_HI)      satVal = SAT_HI[DATA_W-1:0];
    else if (rounded < SAT_LO) satVal = SAT_LO[DATA_W-1:0];
    else                       satVal = rounded[DATA_W-1:0];
  end

  // stage 2: select mute / bypass / scaled result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outSample <= '0;
    end else if (ctl.finish) begin
      if (s1Mute)        outSample <= '0;
      else if (s1Bypass) outSample <= s1Raw;
      else               outSample <= satVal;
    end
  end

  // R7: muted sample comes out as silence
  a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.finish && s1Mute) |=> (outSample == '0));

  // R8: bypassed sample comes out equal to the captured input
  a_r8_bypass_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.finish && s1Bypass && !s1Mute) |=> (outSample == $past(s1Raw)));

  // R2: output holds when no result is produced
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.finish |=> $stable(outSample));

  // R9: captured sample stays put without a strobe
  a_r9_capture_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.load |=> ($stable(s1Raw) && $stable(s1Coef) && $stable(s1Mute)));

endmodule

// File: rtl/speech_gain_stage.sv
module speech_gain_stage
  import sgs_pkg::*;
#(
  parameter int VOL_MAX  = 4,
  parameter int TRIM_MAX = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [SHIFT_W-1:0]  volSel,
  input  logic [TSEL_W-1:0]   trimSel,
  input  logic                muteEn,
  input  logic                bypassEn,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);

  gain_ctl_t ctl;

  sgs_ctrl #(
    .VOL_MAX (VOL_MAX),
    .TRIM_MAX(TRIM_MAX)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .volSel  (volSel),
    .trimSel (trimSel),
    .muteEn  (muteEn),
    .bypassEn(bypassEn),
    .ctl     (ctl),
    .outValid(outValid)
  );

  sgs_datapath #(
    .DATA_W(SAMPLE_W),
    .CW    (COEF_W),
    .FW    (FRAC_W)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .inSample (inSample),
    .outSample(outSample)
  );

endmodule

// File: tb/speech_gain_stage_bench.sv
module speech_gain_stage_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inSample = '0;
  logic [2:0]  volSel = '0;
  logic [3:0]  trimSel = 4'd6;
  logic        muteEn = 1'b0;
  logic        bypassEn = 1'b0;
  logic        outValid;
  logic [15:0] outSample;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  speech_gain_stage u_speech_gain_stage (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSample(inSample),
    .volSel(volSel), .trimSel(trimSel), .muteEn(muteEn), .bypassEn(bypassEn),
    .outValid(outValid), .outSample(outSample)
  );

  // vector: {sample16, vol3, trim4, mute, bypass, expected16, reqTag8}
  function automatic logic [48:0] vec(int x, int v, int t, bit m, bit b, int e, int r);
    return {16'(x), 3'(v), 4'(t), m, b, 16'(e), 8'(r)};
  endfunction

  localparam int NV = 17;
  localparam logic [48:0] VECS [NV] = '{
    vec(1000,   0, 6,  0, 0, 1000,   4),   // R4 unity
    vec(1000,   2, 6,  0, 0, 250,    3),   // R3 -12 dB
    vec(-1001,  1, 6,  0, 0, -501,   3),   // R3 arithmetic shift floors
    vec(20000,  0, 12, 0, 0, 32767,  6),   // R6 positive clamp
    vec(-20000, 0, 12, 0, 0, -32768, 6),   // R6 negative clamp
    vec(10000,  0, 0,  0, 0, 5012,   4),   // R4 -6 dB trim
    vec(3,      0, 7,  0, 0, 3,      5),   // R5 round down
    vec(-3,     0, 7,  0, 0, -3,     5),   // R5 negative rounding
    vec(1,      0, 5,  0, 0, 1,      5),   // R5 round up to 1
    vec(-1,     0, 5,  0, 0, -1,     5),   // R5 nearest for negative
    vec(12345,  3, 6,  1, 0, 0,      7),   // R7 mute
    vec(-12345, 4, 0,  0, 1, -12345, 8),   // R8 bypass ignores gains
    vec(500,    0, 6,  1, 1, 0,      7),   // R7 mute beats bypass
    vec(1600,   7, 6,  0, 0, 100,    3),   // R3 code 7 acts as 4
    vec(1000,   0, 15, 0, 0, 1995,   4),   // R4 code 15 acts as 12
    vec(32767,  0, 6,  0, 0, 32767,  4),   // R4 full-scale unity
    vec(-32768, 4, 6,  0, 0, -2048,  3)    // R3 -24 dB of minimum
  };

  function automatic int coefOf(int t);
    int tab [13] = '{8211, 9213, 10338, 11599, 13014, 14602, 16384,
                     18383, 20626, 23143, 25967, 29135, 32690};
    return tab[(t > 12) ? 12 : t];
  endfunction

  function automatic logic [15:0] model(logic [15:0] x, int v, int t, bit m, bit b);
    longint s, p, q;
    if (m) return 16'd0;
    if (b) return x;
    s = longint'($signed(x)) >>> ((v > 4) ? 4 : v);
    p = s * coefOf(t) + 8192;
    q = p >>> 14;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return 16'(q);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] x, int v, int t, bit m, bit b);
    inValid = 1'b1; inSample = x; volSel = 3'(v); trimSel = 4'(t);
    muteEn = m; bypassEn = b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(outSample == 16'd0, "R1 outSample", $signed(outSample), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [48:0] w;
      w = VECS[i];
      drive(w[48:33], int'(w[32:30]), int'(w[29:26]), w[25], w[24]);
      @(posedge clk); @(negedge clk);
      inValid = 1'b0;
      check(outValid == 1'b0, $sformatf("R2 early valid vec %0d", i), outValid, 0);
      @(posedge clk); @(negedge clk);
      check(outValid == 1'b1, $sformatf("R2 valid vec %0d", i), outValid, 1);
      check(outSample == w[23:8], $sformatf("R%0d vec %0d", w[7:0], i),
            $signed(outSample), $signed(w[23:8]));
      @(posedge clk); @(negedge clk);
      check(outValid == 1'b0, $sformatf("R2 single pulse vec %0d", i), outValid, 0);
      check(outSample == w[23:8], $sformatf("R2 hold vec %0d", i),
            $signed(outSample), $signed(w[23:8]));
    end

    // R9: settings changed right after acceptance do not apply
    drive(16'd800, 0, 6, 0, 0);
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; volSel = 3'd4; trimSel = 4'd0; muteEn = 1'b1;
    @(posedge clk); @(negedge clk);
    check(outValid && outSample == 16'd800, "R9 late change ignored",
          $signed(outSample), 800);
    repeat (2) begin @(posedge clk); @(negedge clk); end
    check(!outValid && outSample == 16'd800, "R9 no strobe no effect",
          $signed(outSample), 800);

    // R10: back-to-back stream with settings flipping each cycle
    begin
      logic [15:0] xs [8];
      int vs [8]; int ts [8]; bit ms [8]; bit bs [8];
      for (int i = 0; i < 8; i++) begin
        xs[i] = 16'(i * 4099 - 15000);
        vs[i] = i % 6; ts[i] = (i * 5) % 14; ms[i] = (i == 5); bs[i] = (i == 3);
      end
      for (int k = 0; k < 10; k++) begin
        if (k >= 2) begin
          logic [15:0] e;
          e = model(xs[k-2], vs[k-2], ts[k-2], ms[k-2], bs[k-2]);
          check(outValid == 1'b1, $sformatf("R10 valid %0d", k - 2), outValid, 1);
          check(outSample == e, $sformatf("R10 stream %0d", k - 2),
                $signed(outSample), $signed(e));
        end
        if (k < 8) drive(xs[k], vs[k], ts[k], ms[k], bs[k]);
        else inValid = 1'b0;
        @(posedge clk); @(negedge clk);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule